// File: doc/BRIEF.md
# Floating-Point Register Bank with Even/Odd Pairing

This block is the operand store of a floating-point coprocessor. It keeps a set of 32-bit data registers that the arithmetic side reads through two read ports and updates through one write port. Each port can move either one 32-bit word or a 64-bit double formed from an aligned pair of registers. The low word of a pair lives in the even register and the high word in the odd register after it. A 64-bit access that names an odd register is rejected: a write changes nothing, and a read returns zero. Both cases are flagged.

Next to the data registers sits the control word. It holds the rounding mode, the condition bit from the last compare, the cause bits of the last exception event, a trap-enable mask, and sticky flags. The sticky flags accumulate causes until software rewrites the control word. A fixed revision word can be read on the control path, and writes to it are dropped. The CPU side has its own 32-bit move ports. One pair moves words into and out of the data registers, and another reads and writes the control and revision words.

All data reads are write-first. A read of a register that is being written in the same cycle returns the incoming word.

Top module: `fp_regbank`

## Requirements
- R1: After reset every data register reads zero, the control word reads 0x00000000, `round_mode` is 00 and `trap_hit` is low.
- R2: A single-width access (`*_wide`=0) touches one 32-bit register. A read returns it in bits 31:0 with bits 63:32 zero, and a write stores bits 31:0 of `wr_data`.
- R3: A wide access at even index n maps bits 31:0 to register n and bits 63:32 to register n+1. This holds for both read ports and the write port.
- R4: A wide access at an odd index is illegal. On the write port it raises `wr_bad` and leaves every register unchanged. On a read port it raises that port's `*_bad` output and returns zero.
- R5: Reads are write-first. In any cycle where the write port or the move-to port writes a register, every data read of that register (ports A and B, and move-from) returns the new word. For a pair, this applies word by word.
- R6: Move-to stores `mv_to_data` into register `mv_to_idx` at the next edge, and `mv_from_data` returns register `mv_from_idx`. When the write port and move-to target the same register in one cycle, the write port's word is kept.
- R7: The control word has this layout. Bits 1:0 hold the rounding mode (00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf). Bits 6:2 are sticky flags, bits 11:7 are trap enables, bits 16:12 are causes, and bit 23 is the condition bit. All other bits read zero. A write with `ctl_wr_en`=1 and `ctl_wr_sel`=0 loads all of these fields from `ctl_wr_data`, and `round_mode` follows bits 1:0.
- R8: A pulse on `cmp_valid` loads the condition bit with `cmp_result`.
- R9: A pulse on `exc_valid` replaces the cause field with `exc_cause` and ORs `exc_cause` into the sticky flags. Sticky flags are never cleared by events. When a control-word write happens in the same cycle as an event, the write wins.
- R10: With select value 1, the control path reads the revision word `REV_ID`. Writes with `ctl_wr_sel`=1 change neither the revision word nor the control word.
- R11: `trap_hit` is high while at least one cause bit has its matching trap-enable bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_wide | input | 1 | Read port A 64-bit pair access |
| rd_a_data | output | 64 | Read port A data |
| rd_a_bad | output | 1 | Read port A illegal pair index |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_wide | input | 1 | Read port B 64-bit pair access |
| rd_b_data | output | 64 | Read port B data |
| rd_b_bad | output | 1 | Read port B illegal pair index |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 5 | Write port register index |
| wr_wide | input | 1 | Write port 64-bit pair access |
| wr_data | input | 64 | Write port data |
| wr_bad | output | 1 | Write port illegal pair index, write dropped |
| mv_to_en | input | 1 | CPU-to-register move enable |
| mv_to_idx | input | 5 | CPU-to-register move index |
| mv_to_data | input | 32 | CPU-to-register move data |
| mv_from_idx | input | 5 | Register-to-CPU move index |
| mv_from_data | output | 32 | Register-to-CPU move data |
| ctl_wr_en | input | 1 | Control path write enable |
| ctl_wr_sel | input | 1 | Control path write target (0 control word, 1 revision) |
| ctl_wr_data | input | 32 | Control path write data |
| ctl_rd_sel | input | 1 | Control path read select (0 control word, 1 revision) |
| ctl_rd_data | output | 32 | Control path read data |
| cmp_valid | input | 1 | Compare result event |
| cmp_result | input | 1 | Compare outcome |
| exc_valid | input | 1 | Exception event |
| exc_cause | input | 5 | Exception causes of the event |
| round_mode | output | 2 | Current rounding mode |
| trap_hit | output | 1 | Enabled cause present |

## Verification
The bench builds the block with its default of 32 registers and a fixed revision value. This gives the last pair (30/31) and register 0, so both ends of the pair mapping are exercised. The table walks single and pair writes and reads, including same-cycle reads that expose the write-first path word by word. Directed steps cover the odd-index rejection on each port, the priority of the write port over move-to, and sticky accumulation over several exception events. They also cover a control write colliding with an event, and writes aimed at the revision word.

// File: rtl/fp_regbank_pkg.sv
package fp_regbank_pkg;
    localparam int WORD_W   = 32;
    localparam int EXC_W    = 5;

    typedef struct packed {
        logic [7:0]       pad_hi;
        logic             cond;
        logic [5:0]       pad_mid;
        logic [EXC_W-1:0] cause;
        logic [EXC_W-1:0] enable;
        logic [EXC_W-1:0] sticky;
        logic [1:0]       rmode;
    } ctl_word_t;

    localparam logic [WORD_W-1:0] CTL_MASK = 32'h0081_FFFF;
endpackage

// File: rtl/fp_ctl_word.sv
module fp_ctl_word
    import fp_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              cmp_valid,
    input  logic              cmp_result,
    input  logic              exc_valid,
    input  logic [EXC_W-1:0]  exc_cause,
    output ctl_word_t         word_q
);
    ctl_word_t word_d;

    always_comb begin
        word_d = word_q;
        if (wr_en) begin
            word_d = ctl_word_t'(wr_data & CTL_MASK);
        end else begin
            if (cmp_valid) begin
                word_d.cond = cmp_result;
            end
            if (exc_valid) begin
                word_d.cause  = exc_cause;
                word_d.sticky = word_q.sticky | exc_cause;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end
endmodule

// File: rtl/fp_reg_store.sv
module fp_reg_store
    import fp_regbank_pkg::*;
#(
    parameter int NUM_REGS = 32,
    localparam int AW = $clog2(NUM_REGS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [AW-1:0]                    wr_idx,
    input  logic                             wr_wide,
    input  logic [2*WORD_W-1:0]              wr_data,
    output logic                             wr_bad,
    input  logic                             mv_en,
    input  logic [AW-1:0]                    mv_idx,
    input  logic [WORD_W-1:0]                mv_data,
    output logic [NUM_REGS-1:0][WORD_W-1:0]  regs_d
);
    logic [NUM_REGS-1:0][WORD_W-1:0] regs_q;
    logic                            wr_ok;
    logic [AW-1:0]                   hi_idx;

    always_comb begin
        wr_bad = wr_en && wr_wide && wr_idx[0];
        wr_ok  = wr_en && !wr_bad;
        hi_idx = wr_idx | AW'(1);
        regs_d = regs_q;
        if (mv_en) begin
            regs_d[mv_idx] = mv_data;
        end
        if (wr_ok) begin
            regs_d[wr_idx] = wr_data[WORD_W-1:0];
            if (wr_wide) begin
                regs_d[hi_idx] = wr_data[2*WORD_W-1:WORD_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end
endmodule

// File: rtl/fp_read_port.sv
module fp_read_port
    import fp_regbank_pkg::*;
#(
    parameter int NUM_REGS = 32,
    localparam int AW = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0][WORD_W-1:0] regs,
    input  logic [AW-1:0]                   idx,
    input  logic                            wide,
    output logic [2*WORD_W-1:0]             data,
    output logic                            bad
);
    always_comb begin
        bad = wide && idx[0];
        if (bad) begin
            data = '0;
        end else if (wide) begin
            data = {regs[idx | AW'(1)], regs[idx]};
        end else begin
            data = {{WORD_W{1'b0}}, regs[idx]};
        end
    end
endmodule

// File: rtl/fp_regbank.sv
module fp_regbank
    import fp_regbank_pkg::*;
#(
    parameter int          NUM_REGS = 32,
    parameter logic [31:0] REV_ID   = 32'h0000_0A01,
    localparam int         AW       = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     rd_a_idx,
    input  logic              rd_a_wide,
    output logic [63:0]       rd_a_data,
    output logic              rd_a_bad,
    input  logic [AW-1:0]     rd_b_idx,
    input  logic              rd_b_wide,
    output logic [63:0]       rd_b_data,
    output logic              rd_b_bad,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_idx,
    input  logic              wr_wide,
    input  logic [63:0]       wr_data,
    output logic              wr_bad,
    input  logic              mv_to_en,
    input  logic [AW-1:0]     mv_to_idx,
    input  logic [31:0]       mv_to_data,
    input  logic [AW-1:0]     mv_from_idx,
    output logic [31:0]       mv_from_data,
    input  logic              ctl_wr_en,
    input  logic              ctl_wr_sel,
    input  logic [31:0]       ctl_wr_data,
    input  logic              ctl_rd_sel,
    output logic [31:0]       ctl_rd_data,
    input  logic              cmp_valid,
    input  logic              cmp_result,
    input  logic              exc_valid,
    input  logic [EXC_W-1:0]  exc_cause,
    output logic [1:0]        round_mode,
    output logic              trap_hit
);
    localparam int NUM_RD = 2;

    logic [NUM_REGS-1:0][WORD_W-1:0] regs_next;
    ctl_word_t                       ctl_word_q;
    logic                            ctl_load;
    logic [NUM_RD-1:0][AW-1:0]       rp_idx;
    logic [NUM_RD-1:0]               rp_wide;
    logic [NUM_RD-1:0][63:0]         rp_data;
    logic [NUM_RD-1:0]               rp_bad;

    assign ctl_load = ctl_wr_en && !ctl_wr_sel;

    fp_reg_store #(.NUM_REGS(NUM_REGS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_wide (wr_wide),
        .wr_data (wr_data),
        .wr_bad  (wr_bad),
        .mv_en   (mv_to_en),
        .mv_idx  (mv_to_idx),
        .mv_data (mv_to_data),
        .regs_d  (regs_next)
    );

    assign rp_idx  = {rd_b_idx, rd_a_idx};
    assign rp_wide = {rd_b_wide, rd_a_wide};

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        fp_read_port #(.NUM_REGS(NUM_REGS)) u_port (
            .regs (regs_next),
            .idx  (rp_idx[p]),
            .wide (rp_wide[p]),
            .data (rp_data[p]),
            .bad  (rp_bad[p])
        );
    end

    assign rd_a_data    = rp_data[0];
    assign rd_a_bad     = rp_bad[0];
    assign rd_b_data    = rp_data[1];
    assign rd_b_bad     = rp_bad[1];
    assign mv_from_data = regs_next[mv_from_idx];

    fp_ctl_word u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (ctl_load),
        .wr_data    (ctl_wr_data),
        .cmp_valid  (cmp_valid),
        .cmp_result (cmp_result),
        .exc_valid  (exc_valid),
        .exc_cause  (exc_cause),
        .word_q     (ctl_word_q)
    );

    assign ctl_rd_data = ctl_rd_sel ? REV_ID : 32'(ctl_word_q);
    assign round_mode  = ctl_word_q.rmode;
    assign trap_hit    = |(ctl_word_q.cause & ctl_word_q.enable);
endmodule

// File: rtl/fp_regbank_chk.sv
module fp_regbank_chk
    import fp_regbank_pkg::*;
#(
    parameter logic [31:0] REV_ID = 32'h0000_0A01
) (
    input logic             clk,
    input logic             rst_n,
    input logic [4:0]       rd_a_idx,
    input logic             rd_a_wide,
    input logic [63:0]      rd_a_data,
    input logic             rd_a_bad,
    input logic             wr_en,
    input logic [4:0]       wr_idx,
    input logic             wr_wide,
    input logic [63:0]      wr_data,
    input logic             ctl_load,
    input logic             ctl_rd_sel,
    input logic [31:0]      ctl_rd_data,
    input logic             cmp_valid,
    input logic             cmp_result,
    input logic             exc_valid,
    input logic [EXC_W-1:0] exc_cause,
    input ctl_word_t        word,
    input logic [1:0]       round_mode
);
    AST_ODD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_wide && rd_a_idx[0]) |-> (rd_a_bad && rd_a_data == 64'd0)); // R4
    AST_BYPASS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_wide && !rd_a_wide && rd_a_idx == wr_idx) |-> (rd_a_data[31:0] == wr_data[31:0])); // R5
    AST_ROUND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_load |=> $stable(round_mode)); // R7
    AST_COND_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !ctl_load) |=> (word.cond == $past(cmp_result))); // R8
    AST_STICKY_OR: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && !ctl_load) |=> ((word.sticky & $past(exc_cause)) == $past(exc_cause))); // R9
    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_load |=> ((word.sticky & $past(word.sticky)) == $past(word.sticky))); // R9
    AST_REV_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rd_sel |-> (ctl_rd_data == REV_ID)); // R10
endmodule

bind fp_regbank fp_regbank_chk #(.REV_ID(REV_ID)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_a_idx    (rd_a_idx),
    .rd_a_wide   (rd_a_wide),
    .rd_a_data   (rd_a_data),
    .rd_a_bad    (rd_a_bad),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_wide     (wr_wide),
    .wr_data     (wr_data),
    .ctl_load    (ctl_load),
    .ctl_rd_sel  (ctl_rd_sel),
    .ctl_rd_data (ctl_rd_data),
    .cmp_valid   (cmp_valid),
    .cmp_result  (cmp_result),
    .exc_valid   (exc_valid),
    .exc_cause   (exc_cause),
    .word        (ctl_word_q),
    .round_mode  (round_mode)
);

// File: tb/fp_regbank_bench.sv
module fp_regbank_bench;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] REV        = 32'h0000_0A01;

    typedef struct packed {
        logic        we;
        logic [4:0]  widx;
        logic        wwide;
        logic [63:0] wdata;
        logic [4:0]  ridx;
        logic        rwide;
        logic [63:0] exp;
        logic        ebad;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 5'd3,  1'b0, 64'h0000_0000_1111_1111, 5'd3,  1'b0, 64'h0000_0000_1111_1111, 1'b0}, // R2 R5
        '{1'b1, 5'd4,  1'b1, 64'hAAAA_0000_BBBB_0001, 5'd4,  1'b1, 64'hAAAA_0000_BBBB_0001, 1'b0}, // R3 R5
        '{1'b0, 5'd0,  1'b0, 64'h0,                   5'd5,  1'b0, 64'h0000_0000_AAAA_0000, 1'b0}, // R3
        '{1'b0, 5'd0,  1'b0, 64'h0,                   5'd4,  1'b0, 64'h0000_0000_BBBB_0001, 1'b0}, // R3
        '{1'b1, 5'd7,  1'b1, 64'h1234_5678_9ABC_DEF0, 5'd7,  1'b0, 64'h0,                   1'b0}, // R4
        '{1'b1, 5'd5,  1'b0, 64'h0000_0000_CAFE_F00D, 5'd4,  1'b1, 64'hCAFE_F00D_BBBB_0001, 1'b0}, // R5
        '{1'b0, 5'd0,  1'b0, 64'h0,                   5'd3,  1'b1, 64'h0,                   1'b1}, // R4
        '{1'b1, 5'd31, 1'b0, 64'h0000_0000_DEAD_BEEF, 5'd30, 1'b1, 64'hDEAD_BEEF_0000_0000, 1'b0}, // R3
        '{1'b1, 5'd0,  1'b1, 64'h0000_000F_0000_0E00, 5'd0,  1'b0, 64'h0000_0000_0000_0E00, 1'b0}  // R3
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0, mv_to_idx = '0, mv_from_idx = '0;
    logic        rd_a_wide = 1'b0, rd_b_wide = 1'b0, wr_en = 1'b0, wr_wide = 1'b0, mv_to_en = 1'b0;
    logic [63:0] wr_data = '0, rd_a_data, rd_b_data;
    logic        rd_a_bad, rd_b_bad, wr_bad;
    logic [31:0] mv_to_data = '0, mv_from_data, ctl_wr_data = '0, ctl_rd_data;
    logic        ctl_wr_en = 1'b0, ctl_wr_sel = 1'b0, ctl_rd_sel = 1'b0;
    logic        cmp_valid = 1'b0, cmp_result = 1'b0, exc_valid = 1'b0;
    logic [4:0]  exc_cause = '0;
    logic [1:0]  round_mode;
    logic        trap_hit;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp_regbank #(.REV_ID(REV)) u_fp_regbank (.*);

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        wr_en = 0; mv_to_en = 0; ctl_wr_en = 0; cmp_valid = 0; exc_valid = 0;
    endtask

    task automatic ctl_read(input string req, input logic [31:0] exp);
        ctl_rd_sel = 0; #1;
        chk(req, {32'd0, ctl_rd_data}, {32'd0, exp});
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd_a_idx = 5'd8; rd_a_wide = 1; #1;
        chk("R1 pair read", rd_a_data, 64'd0);
        ctl_read("R1 control word", 32'd0);
        chk("R1 round/trap", {61'd0, round_mode, trap_hit}, 64'd0);

        // table walk: drive at negedge, check before the edge, commit at edge
        for (int i = 0; i < NV; i++) begin
            wr_en = VEC[i].we; wr_idx = VEC[i].widx; wr_wide = VEC[i].wwide; wr_data = VEC[i].wdata;
            rd_a_idx = VEC[i].ridx; rd_a_wide = VEC[i].rwide; #1;
            chk($sformatf("R2/R3/R4/R5 vec%0d data", i), rd_a_data, VEC[i].exp);
            chk($sformatf("R4 vec%0d bad", i), {63'd0, rd_a_bad}, {63'd0, VEC[i].ebad});
            tick();
        end

        // R3 port B pair read
        rd_b_idx = 5'd4; rd_b_wide = 1; #1;
        chk("R3 port B pair", rd_b_data, 64'hCAFE_F00D_BBBB_0001);
        rd_b_idx = 5'd9; #1;
        chk("R4 port B odd flag", {63'd0, rd_b_bad}, 64'd1);

        // R4 illegal pair write
        wr_en = 1; wr_wide = 1; wr_idx = 5'd9; wr_data = 64'h5555_5555_6666_6666; #1;
        chk("R4 wr_bad", {63'd0, wr_bad}, 64'd1);
        tick();
        rd_a_idx = 5'd9; rd_a_wide = 0; rd_b_idx = 5'd10; rd_b_wide = 0; #1;
        chk("R4 r9 unchanged", rd_a_data, 64'd0);
        chk("R4 r10 unchanged", rd_b_data, 64'd0);

        // R5 / R6 move-to with same-cycle read, then move-from
        mv_to_en = 1; mv_to_idx = 5'd12; mv_to_data = 32'h0000_0055;
        rd_a_idx = 5'd12; mv_from_idx = 5'd12; #1;
        chk("R5 move-to bypass", rd_a_data, 64'h55);
        chk("R5 move-from bypass", {32'd0, mv_from_data}, 64'h55);
        tick();
        mv_from_idx = 5'd12; #1;
        chk("R6 move-from", {32'd0, mv_from_data}, 64'h55);

        // R6 priority: write port beats move-to
        wr_en = 1; wr_wide = 0; wr_idx = 5'd13; wr_data = 64'hAAAA;
        mv_to_en = 1; mv_to_idx = 5'd13; mv_to_data = 32'hBBBB;
        tick();
        mv_from_idx = 5'd13; #1;
        chk("R6 write port wins", {32'd0, mv_from_data}, 64'hAAAA);

        // R10 revision read, writes ignored
        ctl_rd_sel = 1; #1;
        chk("R10 revision", {32'd0, ctl_rd_data}, {32'd0, REV});
        ctl_wr_en = 1; ctl_wr_sel = 1; ctl_wr_data = 32'hFFFF_FFFF;
        tick();
        ctl_wr_sel = 0;
        ctl_rd_sel = 1; #1;
        chk("R10 revision after write", {32'd0, ctl_rd_data}, {32'd0, REV});
        ctl_read("R10 control word untouched", 32'd0);

        // R7 control word write, masking, round mode
        ctl_wr_en = 1; ctl_wr_data = 32'hFFFF_FFFF;
        tick();
        ctl_read("R7 masked write", 32'h0081_FFFF);
        chk("R7 round mode 11", {62'd0, round_mode}, 64'd3);
        chk("R11 trap_hit set", {63'd0, trap_hit}, 64'd1);
        ctl_wr_en = 1; ctl_wr_data = 32'h0000_0001;
        tick();
        chk("R7 round mode 01", {62'd0, round_mode}, 64'd1);

        // R9 exception events accumulate
        exc_valid = 1; exc_cause = 5'b00011;
        tick();
        ctl_read("R9 first event", 32'h0000_300D);
        chk("R11 no enables", {63'd0, trap_hit}, 64'd0);
        exc_valid = 1; exc_cause = 5'b10000;
        tick();
        ctl_read("R9 sticky kept", 32'h0001_004D);

        // R8 compare
        cmp_valid = 1; cmp_result = 1;
        tick();
        ctl_read("R8 cond set", 32'h0081_004D);
        cmp_valid = 1; cmp_result = 0;
        tick();
        ctl_read("R8 cond clear", 32'h0001_004D);

        // R9 write wins over same-cycle event
        ctl_wr_en = 1; ctl_wr_data = 32'h0000_0F80; exc_valid = 1; exc_cause = 5'b00001;
        tick();
        ctl_read("R9 write wins", 32'h0000_0F80);
        chk("R11 cleared causes", {63'd0, trap_hit}, 64'd0);
        exc_valid = 1; exc_cause = 5'b00001;
        tick();
        ctl_read("R9 after clear", 32'h0000_1F84);
        chk("R11 enabled cause", {63'd0, trap_hit}, 64'd1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule